// File: doc/BRIEF.md
# Level-1 / Level-2 Trigger Capture Pipeline

This block holds a continuously sampled multi-wire data stream long enough for a first-level trigger decision to arrive, with no dead time. Each clock (one sample period) a wide word carrying a fixed number of bits per wire is written into a circular memory. A single wrapping sample counter addresses both sides of that memory. The read side trails the write side by a programmable lag, so the data read out at any moment is the data that arrived that many samples earlier.

A first-level accept names one of four capture buffers. Starting with that accept, the buffer records a programmable number of consecutive delayed words. The four buffers fill independently, so fills may overlap in time. A second-level accept names a buffer whose copy is then made into a separate readout memory. After the copy, the readout memory streams the words in order to the downstream stage, which frees the capture buffer for reuse at once.

Top module: `tdc_l1l2_pipe`

## Requirements
- R1: After synchronous reset, `rd_valid`, `rd_last`, `l2_busy` and `l1_err` are all 0.
- R2: The internal sample counter starts at 0 on the first clock edge after reset and advances by one on every edge. Call sample n the `din` value present at edge n. When `l1a` is high at edge n and the active lag is L (valid range 1 to 511), the selected buffer captures samples n-L, n-L+1, and so on.
- R3: The number of words captured per accept is the length register as it was at the accept edge. A write of 0 stores 1. A write above 32 stores 32.
- R4: A fill of one buffer may start while another buffer is still filling. Each buffer ends up holding its own words intact.
- R5: An `l1a` aimed at a buffer that is still filling is ignored, and the ongoing fill continues unchanged. It also sets `l1_err`, which stays 1 until reset.
- R6: When idle, `l2a` copies the buffer selected by `l2a_buf` and then streams its words oldest first on `rd_data` with `rd_valid`. `rd_last` is high on the final word only. `l2_busy` is 1 from the edge after the accept until the final word appears. The first word appears 2+LEN edges after the accept.
- R7: An `l2a` that arrives while `l2_busy` is 1 is ignored and produces no words.
- R8: A lag write takes effect at the edge where the counter goes from 511 to 0. Samples read before that edge use the old lag, including those read by a fill that is in progress.
- R9: Once `l2a` has been taken, the same buffer may be re-armed by `l1a` on the next cycle. The stream still carries the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one edge per sample period |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 480 | Sampled word, 10 bits per wire for 48 wires |
| lat_we | input | 1 | Write strobe for the read lag |
| lat_val | input | 9 | New read lag in samples |
| len_we | input | 1 | Write strobe for the capture length |
| len_val | input | 6 | New capture length in words |
| l1a | input | 1 | First-level accept pulse |
| l1a_buf | input | 2 | Buffer index for the first-level accept |
| l2a | input | 1 | Second-level accept pulse |
| l2a_buf | input | 2 | Buffer index for the second-level accept |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | 480 | Readout word |
| rd_last | output | 1 | Final word of the readout |
| l2_busy | output | 1 | A copy or stream is in progress |
| l1_err | output | 1 | Sticky flag for an accept aimed at a buffer that was still filling |

## Verification
Every sample carries a hash of its own index, so a word streamed with the wrong lag, the wrong offset or the wrong buffer is caught by comparing it against the index it should have. The directed patterns are chosen to separate specific faults. Back-to-back fills into different buffers expose shared-state corruption. A repeated accept into one buffer exposes a missing collision guard. Lengths 0, 1 and 40 exercise the clamp and the one-word readout. A lag write far from a wrap, and a fill that straddles a wrap, show whether the lag switches at the right edge. A second-level accept issued during a stream, and a re-arm right after a copy starts, show that the readout is protected. Randomised mixes of lag and length writes with both kinds of accept then check the interactions against a bench-side model of the requirements.

// File: rtl/tdc_pipe_pkg.sv
package tdc_pipe_pkg;
  typedef enum logic [1:0] {
    RO_IDLE   = 2'd0,
    RO_COPY   = 2'd1,
    RO_FLUSH  = 2'd2,
    RO_STREAM = 2'd3
  } ro_state_t;
endpackage

// File: rtl/tdc_delay_line.sv
// Circular sample memory: one counter addresses both the write and the lagged read.
module tdc_delay_line #(
  parameter int WORD_W  = 480,
  parameter int DEPTH   = 512,   // power of two, counter wraps naturally
  parameter int LAT_RST = 1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic              lat_we,
  input  logic [AW-1:0]     lat_val,
  output logic [WORD_W-1:0] rd_q
);
  logic [AW-1:0]     cnt, lat_pend, lat_act, rd_addr;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      lat_pend <= AW'(LAT_RST);
      lat_act  <= AW'(LAT_RST);
    end else begin
      cnt <= cnt + 1'b1;
      if (lat_we) lat_pend <= lat_val;
      // new lag is applied only as the counter wraps
      if (cnt == AW'(DEPTH-1)) lat_act <= lat_pend;
    end
  end

  assign rd_addr = cnt - lat_act;

  always_ff @(posedge clk) begin
    mem[cnt] <= din;
    rd_q     <= mem[rd_addr];
  end

  // R8: the active lag changes only at the wrap edge
  a_r8_lag_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (lat_act != $past(lat_act)) |-> ($past(cnt) == AW'(DEPTH-1)));
endmodule

// File: rtl/tdc_capture_buf.sv
// One second-level capture buffer with its own fill control.
module tdc_capture_buf #(
  parameter int WORD_W = 480,
  parameter int DEPTH  = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LW-1:0]     len_in,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_q,
  output logic              filling,
  output logic [LW-1:0]     len_q
);
  logic [IW-1:0]     widx;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      filling <= 1'b0;
      widx    <= '0;
      len_q   <= LW'(1);
    end else if (start && !filling) begin
      filling <= 1'b1;
      widx    <= '0;
      len_q   <= len_in;
    end else if (filling) begin
      widx <= widx + 1'b1;
      if (LW'(widx) == len_q - 1'b1) filling <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (filling) mem[widx] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  // R3: the write index never passes the latched length
  a_r3_fill_in_range: assert property (@(posedge clk) disable iff (rst)
    filling |-> (LW'(widx) < len_q));
endmodule

// File: rtl/tdc_readout_copy.sv
// Copies a selected capture buffer into the readout memory, then streams it.
module tdc_readout_copy
  import tdc_pipe_pkg::*;
#(
  parameter int WORD_W = 480,
  parameter int DEPTH  = 32,
  parameter int NBUF   = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(NBUF)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       l2a,
  input  logic [BW-1:0]              l2a_buf,
  input  logic [NBUF-1:0][LW-1:0]    buf_len,
  input  logic [NBUF-1:0][WORD_W-1:0] buf_rd_q,
  output logic [IW-1:0]              buf_rd_addr,
  output logic                       busy,
  output logic                       out_valid,
  output logic [WORD_W-1:0]          out_data,
  output logic                       out_last
);
  ro_state_t         state;
  logic [BW-1:0]     sel;
  logic [LW-1:0]     clen;
  logic [IW-1:0]     idx, cp_a;
  logic              cp_v;
  logic              at_end;
  logic [WORD_W-1:0] ro_mem [DEPTH];

  assign at_end      = (LW'(idx) == clen - 1'b1);
  assign buf_rd_addr = idx;
  assign busy        = (state != RO_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RO_IDLE;
      sel       <= '0;
      clen      <= LW'(1);
      idx       <= '0;
      cp_v      <= 1'b0;
      cp_a      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      cp_v      <= (state == RO_COPY);
      cp_a      <= idx;
      out_valid <= (state == RO_STREAM);
      out_last  <= (state == RO_STREAM) && at_end;
      case (state)
        RO_IDLE: if (l2a) begin
          state <= RO_COPY;
          sel   <= l2a_buf;
          clen  <= buf_len[l2a_buf];
          idx   <= '0;
        end
        RO_COPY: begin
          idx <= idx + 1'b1;
          if (at_end) state <= RO_FLUSH;
        end
        RO_FLUSH: begin
          idx   <= '0;
          state <= RO_STREAM;
        end
        default: begin
          idx <= idx + 1'b1;
          if (at_end) state <= RO_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cp_v) ro_mem[cp_a] <= buf_rd_q[sel];
    out_data <= ro_mem[idx];
  end

  // R6: the last marker only rides on a valid word
  a_r6_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R6: nothing is streamed while the copy is running
  a_r6_quiet_in_copy: assert property (@(posedge clk) disable iff (rst)
    (state == RO_COPY) |-> !out_valid);
  // R7: the selected buffer cannot change while busy
  a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
    (state != RO_IDLE) |=> (sel == $past(sel)));
endmodule

// File: rtl/tdc_l1l2_pipe.sv
module tdc_l1l2_pipe #(
  parameter int WIRES         = 48,
  parameter int BITS_PER_WIRE = 10,
  parameter int PIPE_DEPTH    = 512,
  parameter int BUF_DEPTH     = 32,
  parameter int NUM_BUFS      = 4,
  parameter int LAT_RST       = 1,
  parameter int LEN_RST       = 8,
  localparam int WORD_W = WIRES * BITS_PER_WIRE,
  localparam int PAW    = $clog2(PIPE_DEPTH),
  localparam int LW     = $clog2(BUF_DEPTH + 1),
  localparam int IW     = $clog2(BUF_DEPTH),
  localparam int BW     = $clog2(NUM_BUFS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic              lat_we,
  input  logic [PAW-1:0]    lat_val,
  input  logic              len_we,
  input  logic [LW-1:0]     len_val,
  input  logic              l1a,
  input  logic [BW-1:0]     l1a_buf,
  input  logic              l2a,
  input  logic [BW-1:0]     l2a_buf,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_last,
  output logic              l2_busy,
  output logic              l1_err
);
  logic [WORD_W-1:0]               dly_q;
  logic [LW-1:0]                   len_reg;
  logic [NUM_BUFS-1:0]             filling;
  logic [NUM_BUFS-1:0][LW-1:0]     buf_len;
  logic [NUM_BUFS-1:0][WORD_W-1:0] buf_q;
  logic [IW-1:0]                   buf_rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_reg <= LW'(LEN_RST);
      l1_err  <= 1'b0;
    end else begin
      if (len_we) begin
        if (len_val == '0)                  len_reg <= LW'(1);
        else if (len_val > LW'(BUF_DEPTH))  len_reg <= LW'(BUF_DEPTH);
        else                                len_reg <= len_val;
      end
      if (l1a && filling[l1a_buf]) l1_err <= 1'b1;
    end
  end

  tdc_delay_line #(.WORD_W(WORD_W), .DEPTH(PIPE_DEPTH), .LAT_RST(LAT_RST)) u_dly (
    .clk(clk), .rst(rst), .din(din), .lat_we(lat_we), .lat_val(lat_val), .rd_q(dly_q)
  );

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
    tdc_capture_buf #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst(rst),
      .start(l1a && (l1a_buf == BW'(g))),
      .len_in(len_reg), .wr_data(dly_q), .rd_addr(buf_rd_addr),
      .rd_q(buf_q[g]), .filling(filling[g]), .len_q(buf_len[g])
    );
  end

  tdc_readout_copy #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH), .NBUF(NUM_BUFS)) u_ro (
    .clk(clk), .rst(rst), .l2a(l2a), .l2a_buf(l2a_buf),
    .buf_len(buf_len), .buf_rd_q(buf_q), .buf_rd_addr(buf_rd_addr),
    .busy(l2_busy), .out_valid(rd_valid), .out_data(rd_data), .out_last(rd_last)
  );

  // R5: a collision sets the error flag on the next cycle
  a_r5_err_on_collision: assert property (@(posedge clk) disable iff (rst)
    (l1a && filling[l1a_buf]) |=> l1_err);
  // R5: the error flag is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    l1_err |=> l1_err);
  // R4: an accept to an idle buffer starts its fill whatever the others do
  a_r4_fill_starts: assert property (@(posedge clk) disable iff (rst)
    (l1a && !filling[l1a_buf]) |=> filling[$past(l1a_buf)]);
endmodule

// File: tb/tdc_l1l2_pipe_bench.sv
`timescale 1ns/1ps
module tdc_l1l2_pipe_bench;
  localparam int W = 480, PD = 512, BD = 32, NB = 4, LAT0 = 1, LEN0 = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] din = '0;
  logic lat_we = 0, len_we = 0, l1a = 0, l2a = 0;
  logic [8:0] lat_val = '0;
  logic [5:0] len_val = '0;
  logic [1:0] l1a_buf = '0, l2a_buf = '0;
  logic rd_valid, rd_last, l2_busy, l1_err;
  logic [W-1:0] rd_data;

  always #2.5 clk = ~clk;

  tdc_l1l2_pipe u_tdc_l1l2_pipe (
    .clk(clk), .rst(rst), .din(din), .lat_we(lat_we), .lat_val(lat_val),
    .len_we(len_we), .len_val(len_val), .l1a(l1a), .l1a_buf(l1a_buf),
    .l2a(l2a), .l2a_buf(l2a_buf), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .l2_busy(l2_busy), .l1_err(l1_err));

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic logic [31:0] mix(int a, int b);
    logic [31:0] x;
    x = a * 32'h9E3779B1 ^ (b + 1) * 32'h85EBCA6B;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    return x ^ (x >> 12);
  endfunction

  function automatic logic [W-1:0] pat(int idx);
    logic [W-1:0] v;
    for (int j = 0; j < W / 32; j++) v[j*32 +: 32] = mix(idx, j);
    return v;
  endfunction

  function automatic int clamp_len(int v);
    if (v == 0) return 1;
    if (v > BD) return BD;
    return v;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---- reference model of the requirements ----
  int k, m_act, m_pend, m_len, busy_cnt, prev_s, s_now;
  bit m_err;
  bit m_fill [NB];
  int m_idx [NB], m_flen [NB];
  int m_buf [NB][BD];
  logic [W:0] exp_q [$];

  always @(posedge clk) begin
    if (rst) begin
      k <= 0; m_act <= LAT0; m_pend <= LAT0; m_len <= LEN0;
      busy_cnt <= 0; prev_s <= 0; m_err <= 0;
      for (int b = 0; b < NB; b++) begin m_fill[b] <= 0; m_idx[b] <= 0; m_flen[b] <= 1; end
    end else begin
      s_now = k - m_act;
      if (k % PD == PD - 1) m_act <= m_pend;
      if (lat_we) m_pend <= lat_val;
      if (len_we) m_len <= clamp_len(len_val);
      for (int b = 0; b < NB; b++)
        if (m_fill[b]) begin
          m_buf[b][m_idx[b]] <= prev_s;
          m_idx[b] <= m_idx[b] + 1;
          if (m_idx[b] == m_flen[b] - 1) m_fill[b] <= 0;
        end
      if (l1a) begin
        if (m_fill[l1a_buf]) m_err <= 1;
        else begin m_fill[l1a_buf] <= 1; m_idx[l1a_buf] <= 0; m_flen[l1a_buf] <= m_len; end
      end
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      else if (l2a) begin
        busy_cnt <= 2 * m_flen[l2a_buf] + 1;
        for (int i = 0; i < m_flen[l2a_buf]; i++)
          exp_q.push_back({(i == m_flen[l2a_buf] - 1), pat(m_buf[l2a_buf][i])});
      end
      prev_s <= s_now;
      k <= k + 1;
    end
  end

  always @(negedge clk) din <= pat(k);

  // ---- output scoreboard ----
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s: actual extra word %h expected no word (R7)", cur_req, rd_data);
      end else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        check(cur_req, rd_data, e[W-1:0]);
        check({cur_req, " R6 last"}, W'(rd_last), W'(e[W]));
      end
    end
  end

  // ---- stimulus tasks ----
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_lat(int v);
    @(negedge clk); lat_we = 1; lat_val = 9'(v);
    @(negedge clk); lat_we = 0;
  endtask
  task automatic set_len(int v);
    @(negedge clk); len_we = 1; len_val = 6'(v);
    @(negedge clk); len_we = 0;
  endtask
  task automatic do_l1(int b);
    @(negedge clk); l1a = 1; l1a_buf = 2'(b);
    @(negedge clk); l1a = 0;
  endtask
  task automatic do_l2(int b);
    @(negedge clk); l2a = 1; l2a_buf = 2'(b);
    @(negedge clk); l2a = 0;
  endtask
  task automatic wait_lat;
    while (m_act != m_pend) @(negedge clk);
  endtask
  task automatic drain;
    bit any;
    do begin
      @(negedge clk);
      any = (busy_cnt != 0) || (exp_q.size() != 0);
      for (int b = 0; b < NB; b++) any |= m_fill[b];
    end while (any);
    cyc(3);
  endtask
  task automatic wait_phase(int ph);
    while (k % PD != ph) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(5);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 rd_valid", W'(rd_valid), '0);
    check("R1 l2_busy", W'(l2_busy), '0);
    check("R1 l1_err", W'(l1_err), '0);
    check("R1 rd_last", W'(rd_last), '0);

    // fill the pipeline once before any capture
    cyc(PD + 10);
    cur_req = "R2 R3";
    set_len(5); set_lat(20); wait_lat();
    do_l1(0); cyc(10);
    cur_req = "R6";
    do_l2(0);
    check("R6 busy after accept", W'(l2_busy), W'(1'b1));
    drain();
    check("R6 busy cleared", W'(l2_busy), '0);

    // R4: overlapping fills into two buffers
    cur_req = "R4";
    set_len(8);
    do_l1(1); do_l1(2);
    cyc(12);
    do_l2(1); drain(); do_l2(2); drain();

    // R5: second accept into a buffer still filling
    cur_req = "R5";
    check("R5 flag clear before", W'(l1_err), '0);
    set_len(10);
    do_l1(3); set_len(3); do_l1(3);
    check("R5 flag set", W'(l1_err), W'(1'b1));
    cyc(14);
    // R7: second-level accept during a stream is dropped
    cur_req = "R7";
    do_l2(3); do_l2(1);
    drain();
    check("R7 queue empty", W'(exp_q.size()), '0);
    check("R5 flag sticky", W'(l1_err), W'(1'b1));

    // R3: length clamps and single word
    cur_req = "R3 len0";
    set_len(0); do_l1(0); cyc(4); do_l2(0); drain();
    cur_req = "R3 len40";
    set_len(40); do_l1(2); cyc(36); do_l2(2); drain();
    cur_req = "R3 len1";
    set_len(1); do_l1(1); cyc(3); do_l2(1); drain();

    // R9: re-arm a buffer right after its copy starts
    cur_req = "R9";
    set_len(6); do_l1(0); cyc(8);
    set_lat(7); wait_lat();
    do_l2(0); do_l1(0);
    drain();
    do_l2(0); drain();

    // R8: lag write far from a wrap must not act at once
    cur_req = "R8 far";
    wait_phase(100);
    set_lat(45); do_l1(1); cyc(6); do_l2(1); drain();
    // R8: fill straddling the wrap picks up the new lag mid-fill
    cur_req = "R8 wrap";
    set_len(12);
    wait_phase(PD - 8);
    do_l1(2); cyc(16); do_l2(2); drain();
    check("R8 lag now active", W'(m_act), W'(45));

    // random mix
    cur_req = "R2 R4 R6 random";
    for (int it = 0; it < 60; it++) begin
      int op, b;
      op = int'($urandom % 4);
      b  = int'($urandom % NB);
      case (op)
        0: set_lat(1 + int'($urandom % 511));
        1: set_len(int'($urandom % 41));
        2: do_l1(b);
        default: if (!m_fill[b]) do_l2(b);
      endcase
      cyc(int'($urandom % 25));
    end
    drain();
    check("R5 flag matches model", W'(l1_err), W'(m_err));
    check("R6 idle at end", W'(l2_busy), '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule